// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Chain

This block is a synchronous up-counter built from 4-bit counting stages. Each stage counts in binary and wraps modulo 16. It has an active-low clear that acts at once, without a clock edge. It also has an active-low synchronous parallel load and two count enables with separate jobs. The first enable, `count_en`, goes to every stage and allows counting. The second, the chain enable, gates counting and also gates the stage's combinational carry.

The top module chains `STAGES` counting stages. The carry of each stage drives the chain enable of the next stage. The shared `count_en` drives every stage. Together they form one `4*STAGES`-bit synchronous counter. The carry of the last stage appears at `carry_out`, so several of these blocks can be cascaded into a wider counter. The operations rank in this order: clear first, then load, then count, then hold.

Top module: `sync_bin_chain`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros at once, without waiting for a rising clock edge.
- R2: With `clear_n` high and `load_n` low, a rising edge copies `data` into `q`, whatever the values of `count_en` and `chain_en`.
- R3: With `clear_n` and `load_n` both high and both `count_en` and `chain_en` high, a rising edge increments `q` by one.
- R4: With `clear_n` and `load_n` both high and either `count_en` or `chain_en` low, `q` keeps its value across the rising edge.
- R5: Counting is binary, and the value after all ones is zero. At 4 bits per stage the value after 15 is 0.
- R6: `carry_out` equals `chain_en` AND (`q` is all ones). It is combinational, and `count_en` has no effect on it.
- R7: The following sequence works, read in the low stage: clear to 0, load 12, count through 13, 14, 15, 0, 1 and 2, then inhibit counting and hold at 2.
- R8: The carry of each stage enables the next stage, so the chain counts as one `4*STAGES`-bit binary counter. For example, 0x0F steps to 0x10.
- R9: Clear beats load: a rising edge while `clear_n` is low leaves `q` at zero, even with `load_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| count_en | input | 1 | Count enable shared by all stages; does not gate the carry |
| chain_en | input | 1 | Count enable of stage 0; also gates `carry_out` |
| data | input | 4*STAGES | Parallel load value |
| q | output | 4*STAGES | Counter value |
| carry_out | output | 1 | Ripple carry of the last stage |

## Verification
The results fall due at three different times:
- **Clear** reaches `q` with no clock. The bench checks it one nanosecond after `clear_n` falls in the middle of a cycle.
- **Carry** is combinational. It is checked after the inputs are driven at the falling edge and before the next rising edge.
- **Load, count and hold** take effect at the next rising edge. Their `q` value is checked one nanosecond after that edge.

At every step the bench compares both outputs with a reference value. It computes that value itself from the applied inputs and the priority rules.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int STAGE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_t,
    output logic             carry
);
    always_comb begin
        carry = en_t && (cnt == {WIDTH{1'b1}});
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int WIDTH = STAGE_W
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             carry
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } stage_t;

    stage_t  st_d, st_q;
    cnt_op_e op;

    cnt_op_sel u_sel (
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.value = din;
            OP_COUNT: st_d.value = st_q.value + ONE;
            default:  st_d.value = st_q.value;
        endcase
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt = st_q.value;

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cnt   (st_q.value),
        .en_t  (en_t),
        .carry (carry)
    );

    AST_CLEAR_ZERO: assert property (@(negedge clk) !clear_n |-> cnt == '0); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && !$past(load_n)) |-> cnt == $past(din)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(load_n) && $past(en_p) && $past(en_t))
        |-> cnt == $past(cnt) + ONE); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(load_n) && !($past(en_p) && $past(en_t)))
        |-> $stable(cnt)); // R4

    AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!clear_n)
        carry |-> (en_t && cnt == {WIDTH{1'b1}})); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(load_n) && $past(en_p) && $past(en_t)
         && $past(cnt) == {WIDTH{1'b1}}) |-> cnt == '0); // R5
endmodule

// File: rtl/sync_bin_chain.sv
module sync_bin_chain
    import cnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int W = STAGE_W * STAGES
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         count_en,
    input  logic         chain_en,
    input  logic [W-1:0] data,
    output logic [W-1:0] q,
    output logic         carry_out
);
    logic [STAGES:0] t_chain;

    assign t_chain[0] = chain_en;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cnt_stage #(.WIDTH(STAGE_W)) u_stage (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .en_p    (count_en),
            .en_t    (t_chain[i]),
            .din     (data[i*STAGE_W +: STAGE_W]),
            .cnt     (q[i*STAGE_W +: STAGE_W]),
            .carry   (t_chain[i+1])
        );
    end

    assign carry_out = t_chain[STAGES];

    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(load_n) && $past(count_en) && $past(chain_en))
        |-> q == $past(q) + W'(1)); // R8

    AST_CLEAR_OVER_LOAD: assert property (@(negedge clk)
        (!clear_n && !load_n) |-> q == '0); // R9
endmodule

// File: tb/sync_bin_chain_tb.sv
module sync_bin_chain_tb;
    localparam int STAGES = 2;
    localparam int W = 4 * STAGES;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         load_n = 1'b1;
    logic         count_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] q;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_bin_chain #(.STAGES(STAGES)) u_dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .load_n    (load_n),
        .count_en  (count_en),
        .chain_en  (chain_en),
        .data      (data),
        .q         (q),
        .carry_out (carry_out)
    );

    function automatic logic [W-1:0] next_val(logic cl, logic ld, logic cp, logic ct,
                                              logic [W-1:0] d, logic [W-1:0] cur);
        if (!cl) return '0;
        if (!ld) return d;
        if (cp && ct) return cur + W'(1);
        return cur;
    endfunction

    function automatic logic exp_carry(logic ct, logic [W-1:0] cur);
        return ct && (cur == {W{1'b1}});
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(string req, logic cl, logic ld, logic cp, logic ct, logic [W-1:0] d);
        @(negedge clk);
        clear_n = cl; load_n = ld; count_en = cp; chain_en = ct; data = d;
        #1;
        if (cl) chk("R6 carry", W'(carry_out), W'(exp_carry(ct, model)));
        @(posedge clk);
        model = next_val(cl, ld, cp, ct, d, model);
        #1;
        chk(req, q, model);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        chk("R1 reset state", q, '0);
        step("R9 clear beats load", 1'b0, 1'b0, 1'b1, 1'b1, W'(8'hA5));

        // R7 directed sequence
        step("R7 clear", 1'b0, 1'b1, 1'b0, 1'b0, '0);
        step("R7 load 12", 1'b1, 1'b0, 1'b0, 1'b0, W'(12));
        for (int k = 0; k < 6; k++) begin
            step("R7 count", 1'b1, 1'b1, 1'b1, 1'b1, '0);
            chk("R7 low stage", W'(q[3:0]), W'((13 + k) % 16));
        end
        step("R7 inhibit p", 1'b1, 1'b1, 1'b0, 1'b1, '0);
        step("R7 inhibit t", 1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R7 held at 2", W'(q[3:0]), W'(2));
        chk("R8 chain 0x12", q, W'(8'h12));

        // R8 cross a stage boundary
        step("R2 load 0x0F", 1'b1, 1'b0, 1'b0, 1'b0, W'(8'h0F));
        step("R8 0x0F to 0x10", 1'b1, 1'b1, 1'b1, 1'b1, '0);

        // R6 enable_p has no effect on carry
        step("R2 load all ones", 1'b1, 1'b0, 1'b1, 1'b0, {W{1'b1}});
        step("R4 hold p low", 1'b1, 1'b1, 1'b0, 1'b1, '0);
        step("R4 hold t low", 1'b1, 1'b1, 1'b1, 1'b0, '0);
        // R2 load at terminal count while counting enabled
        step("R2 load at terminal", 1'b1, 1'b0, 1'b1, 1'b1, W'(5));
        // R5 wrap
        step("R2 load all ones", 1'b1, 1'b0, 1'b0, 1'b0, {W{1'b1}});
        step("R5 wrap to zero", 1'b1, 1'b1, 1'b1, 1'b1, '0);

        // R1 mid-cycle clear, spanning an edge with load requested
        step("R2 load 0x3C", 1'b1, 1'b0, 1'b0, 1'b0, W'(8'h3C));
        @(negedge clk);
        load_n = 1'b1; count_en = 1'b0; chain_en = 1'b0;
        #2;
        clear_n = 1'b0;
        #1;
        model = '0;
        chk("R1 async clear", q, '0);
        step("R9 held clear", 1'b0, 1'b0, 1'b1, 1'b1, W'(8'h77));

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic cl, ld, cp, ct;
            logic [W-1:0] d;
            cl = ($urandom % 20) != 0;
            ld = ($urandom % 6) != 0;
            cp = ($urandom % 4) != 0;
            ct = ($urandom % 4) != 0;
            d  = W'($urandom);
            step("R3 random", cl, ld, cp, ct, d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule